// File: doc/BRIEF.md
# UART Register File with Busy Lock

This block is the software-visible control and status register set of a 16550-style UART. A byte-wide register bus reaches it. The bus carries a word index, a write strobe, a read strobe and write data. Read data is combinational from the index, and the side effects of a read or write take effect at the clock edge on which the strobe is sampled high. The block holds the line control, interrupt enable, divisor, FIFO-enable and scratch state. It drives the divisor value and the line configuration to the serial engine, and it builds the interrupt identification code and the interrupt line.

The serial shifters, baud generator and FIFOs sit outside. Plain level flags stand in for them: engine busy, receive data ready, transmit empty, line error and receive timeout, together with a receive byte and a modem status byte. Transmit and receive data cross the edge as single-cycle strobes. `tx_push` qualifies `tx_byte` on a data-index write, and `rx_pop` marks that `rx_byte` was consumed on a data-index read. There is no back-pressure on either strobe. The engine must accept or supply a byte in the cycle the strobe is high.

While the engine reports busy, the line control register is locked. A write to it is dropped, and the dropped write latches a busy-detect interrupt. Only a read of the status register at index 0x1F clears that interrupt.

Top module: `uartcsr_top`

## Requirements
- R1: After reset, line control reads 0x03, interrupt enable reads 0x00, the divisor output is 0x0001, scratch reads 0x00, the identification register reads 0x01 and `irq` is low.
- R2: With the engine idle, a write to index 3 stores the byte; a readback and `line_cfg` both return it on the following cycle.
- R3: With `eng_busy` high, a write to index 3 leaves line control unchanged in every bit, including bit 7 (divisor access).
- R4: A write to index 3 with `eng_busy` high latches a busy-detect interrupt: `irq` rises and, with no higher source active, the identification low nibble reads 0x7. The interrupt enable bits cannot mask it.
- R5: A read of index 0x1F clears a pending busy-detect interrupt; bit 0 of that register reads the live `eng_busy` and its other bits read 0.
- R6: Identification bit 0 is 1 when nothing is pending. The codes and enables are: line error 0x6 (enable bit 2), receive ready 0x4 (enable bit 0), receive timeout 0xC (enable bit 0), transmit empty 0x2 (enable bit 1) and busy-detect 0x7. Priority runs in that order, highest first.
- R7: When line control bit 7 is set, index 0 reads and writes the low divisor byte and index 1 the high divisor byte, and `divisor` = {high, low}. The divisor changes only through such writes.
- R8: When bit 7 is clear, a write to index 0 pulses `tx_push` with `tx_byte` equal to the written byte. A read of index 0 returns `rx_byte` and pulses `rx_pop`. Index 1 stores the low four enable bits, and its upper bits read 0.
- R9: Index 7 reads back the last byte written to it; index 6 returns `msr_in`.
- R10: Bit 0 of a write to index 2 sets the FIFO-enable state; identification bits 7:6 read 11 when it is set and 00 when it is clear.
- R11: Index 5 reads {0, `tx_empty` and not `eng_busy`, `tx_empty`, 000, `line_err`, `rx_ready`}; index 4 and every other unlisted index read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current index |
| eng_busy | input | 1 | Serial engine has a character in flight |
| rx_ready | input | 1 | Receive data available |
| tx_empty | input | 1 | Transmit holding empty |
| line_err | input | 1 | Receive line error present |
| rx_timeout | input | 1 | Receive character timeout |
| rx_byte | input | 8 | Byte at the head of receive |
| msr_in | input | 8 | Modem status byte |
| tx_push | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive byte consumed strobe |
| divisor | output | 16 | Baud divisor |
| line_cfg | output | 8 | Line configuration |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the bus never raises `bus_wr` and `bus_rd` in the same cycle. They also assume that every input, status flags included, changes only between clock edges. Otherwise the lock and clear properties would be judged against a busy value the register did not see. The stimulus drives all inputs at the falling edge. It randomises the flags and the busy level before each single bus operation, so locked writes and status-register clears interleave with the other traffic without ever overlapping.

// File: rtl/uartcsr_pkg.sv
package uartcsr_pkg;
  localparam int BYTE_W = 8;
  localparam int IER_W  = 4;

  localparam logic [4:0] IDX_DATA = 5'h00;
  localparam logic [4:0] IDX_IER  = 5'h01;
  localparam logic [4:0] IDX_IIR  = 5'h02;
  localparam logic [4:0] IDX_LCR  = 5'h03;
  localparam logic [4:0] IDX_LSR  = 5'h05;
  localparam logic [4:0] IDX_MSR  = 5'h06;
  localparam logic [4:0] IDX_SCR  = 5'h07;
  localparam logic [4:0] IDX_USR  = 5'h1F;

  localparam int DLAB_BIT = 7;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_RXTO = 4'hC;
  localparam logic [3:0] CODE_TXE  = 4'h2;
  localparam logic [3:0] CODE_BUSY = 4'h7;

  localparam int NSRC = 5;

  typedef struct packed {
    logic line;
    logic rxd;
    logic rxto;
    logic txe;
    logic busy;
  } irq_src_t;
endpackage

// File: rtl/uartcsr_regs.sv
module uartcsr_regs
  import uartcsr_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [7:0]  LCR_RST = 8'h03,
  parameter logic [15:0] DIV_RST = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              eng_busy,
  output logic [BYTE_W-1:0] lcr,
  output logic [IER_W-1:0]  ier,
  output logic [BYTE_W-1:0] dll,
  output logic [BYTE_W-1:0] dlh,
  output logic [BYTE_W-1:0] scr,
  output logic              fifo_en,
  output logic              busy_pend,
  output logic              tx_push,
  output logic              rx_pop
);
  localparam int AW = ADDR_W;

  logic dlab;
  logic hit_data, hit_ier, hit_iir, hit_lcr, hit_scr, hit_usr;

  assign dlab     = lcr[DLAB_BIT];
  assign hit_data = (addr == AW'(IDX_DATA));
  assign hit_ier  = (addr == AW'(IDX_IER));
  assign hit_iir  = (addr == AW'(IDX_IIR));
  assign hit_lcr  = (addr == AW'(IDX_LCR));
  assign hit_scr  = (addr == AW'(IDX_SCR));
  assign hit_usr  = (addr == AW'(IDX_USR));

  assign tx_push = wr && hit_data && !dlab;
  assign rx_pop  = rd && hit_data && !dlab;

  // line control with busy lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= LCR_RST;
    end else if (wr && hit_lcr && !eng_busy) begin
      lcr <= wdata;
    end
  end

  // busy-detect: set by a locked write, cleared by status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_pend <= 1'b0;
    end else if (wr && hit_lcr && eng_busy) begin
      busy_pend <= 1'b1;
    end else if (rd && hit_usr) begin
      busy_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll <= DIV_RST[7:0];
      dlh <= DIV_RST[15:8];
    end else if (wr && dlab) begin
      if (hit_data) dll <= wdata;
      if (hit_ier)  dlh <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0;
    end else if (wr && hit_ier && !dlab) begin
      ier <= wdata[IER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr     <= '0;
      fifo_en <= 1'b0;
    end else if (wr) begin
      if (hit_scr) scr <= wdata;
      if (hit_iir) fifo_en <= wdata[0];
    end
  end
endmodule

// File: rtl/uartcsr_irq.sv
module uartcsr_irq
  import uartcsr_pkg::*;
(
  input  logic [IER_W-1:0] ier,
  input  logic             line_err,
  input  logic             rx_ready,
  input  logic             rx_timeout,
  input  logic             tx_empty,
  input  logic             busy_pend,
  output logic [3:0]       code,
  output logic             irq
);
  irq_src_t            src;
  logic [NSRC-1:0]     act;
  logic [NSRC-1:0][3:0] codes;

  assign src.line = line_err   && ier[2];
  assign src.rxd  = rx_ready   && ier[0];
  assign src.rxto = rx_timeout && ier[0];
  assign src.txe  = tx_empty   && ier[1];
  assign src.busy = busy_pend;

  // index 0 is lowest priority, NSRC-1 highest
  assign act   = {src.line, src.rxd, src.rxto, src.txe, src.busy};
  assign codes = {CODE_LINE, CODE_RXD, CODE_RXTO, CODE_TXE, CODE_BUSY};

  logic [NSRC:0][3:0] chain;
  assign chain[0] = CODE_NONE;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_prio
      assign chain[gi+1] = act[gi] ? codes[gi] : chain[gi];
    end
  endgenerate

  assign code = chain[NSRC];
  assign irq  = |act;
endmodule

// File: rtl/uartcsr_rdmux.sv
module uartcsr_rdmux
  import uartcsr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] lcr,
  input  logic [IER_W-1:0]  ier,
  input  logic [BYTE_W-1:0] dll,
  input  logic [BYTE_W-1:0] dlh,
  input  logic [BYTE_W-1:0] scr,
  input  logic              fifo_en,
  input  logic [3:0]        code,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] msr_in,
  input  logic              eng_busy,
  input  logic              rx_ready,
  input  logic              tx_empty,
  input  logic              line_err,
  output logic [BYTE_W-1:0] rdata
);
  localparam int AW = ADDR_W;

  logic            dlab;
  logic [BYTE_W-1:0] iir, lsr, usr;

  assign dlab = lcr[DLAB_BIT];
  assign iir  = {fifo_en, fifo_en, 2'b00, code};
  assign lsr  = {1'b0, tx_empty & ~eng_busy, tx_empty, 3'b000, line_err, rx_ready};
  assign usr  = {{(BYTE_W-1){1'b0}}, eng_busy};

  always_comb begin
    rdata = '0;
    unique case (addr)
      AW'(IDX_DATA): rdata = dlab ? dll : rx_byte;
      AW'(IDX_IER):  rdata = dlab ? dlh : {{(BYTE_W-IER_W){1'b0}}, ier};
      AW'(IDX_IIR):  rdata = iir;
      AW'(IDX_LCR):  rdata = lcr;
      AW'(IDX_LSR):  rdata = lsr;
      AW'(IDX_MSR):  rdata = msr_in;
      AW'(IDX_SCR):  rdata = scr;
      AW'(IDX_USR):  rdata = usr;
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/uartcsr_top.sv
module uartcsr_top
  import uartcsr_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [7:0]  LCR_RST = 8'h03,
  parameter logic [15:0] DIV_RST = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              eng_busy,
  input  logic              rx_ready,
  input  logic              tx_empty,
  input  logic              line_err,
  input  logic              rx_timeout,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        msr_in,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  output logic [15:0]       divisor,
  output logic [7:0]        line_cfg,
  output logic              irq
);
  logic [BYTE_W-1:0] lcr, dll, dlh, scr;
  logic [IER_W-1:0]  ier;
  logic              fifo_en, busy_pend;
  logic [3:0]        code;

  uartcsr_regs #(
    .ADDR_W(ADDR_W), .LCR_RST(LCR_RST), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .eng_busy(eng_busy), .lcr(lcr), .ier(ier),
    .dll(dll), .dlh(dlh), .scr(scr), .fifo_en(fifo_en),
    .busy_pend(busy_pend), .tx_push(tx_push), .rx_pop(rx_pop)
  );

  uartcsr_irq u_irq (
    .ier(ier), .line_err(line_err), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .tx_empty(tx_empty), .busy_pend(busy_pend),
    .code(code), .irq(irq)
  );

  uartcsr_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr(bus_addr), .lcr(lcr), .ier(ier), .dll(dll), .dlh(dlh), .scr(scr),
    .fifo_en(fifo_en), .code(code), .rx_byte(rx_byte), .msr_in(msr_in),
    .eng_busy(eng_busy), .rx_ready(rx_ready), .tx_empty(tx_empty),
    .line_err(line_err), .rdata(bus_rdata)
  );

  assign tx_byte  = bus_wdata;
  assign divisor  = {dlh, dll};
  assign line_cfg = lcr;
endmodule

// File: rtl/uartcsr_chk.sv
module uartcsr_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              eng_busy,
  input logic              rx_ready,
  input logic              tx_empty,
  input logic              line_err,
  input logic              rx_timeout,
  input logic [15:0]       divisor,
  input logic [7:0]        line_cfg,
  input logic              irq,
  input logic              busy_pend
);
  logic lcr_hit, usr_hit, div_hit;
  assign lcr_hit = bus_addr == ADDR_W'(3);
  assign usr_hit = bus_addr == ADDR_W'(31);
  assign div_hit = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(1));

  // R3
  lcr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lcr_hit && eng_busy) |=> $stable(line_cfg));

  // R4
  busy_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lcr_hit && eng_busy) |=> (irq && busy_pend));

  // R5
  usr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && usr_hit) |=> !busy_pend);

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && line_cfg[7] && div_hit) |=> $stable(divisor));

  // R6
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_pend && !line_err && !rx_ready && !rx_timeout && !tx_empty) |-> !irq);
endmodule

bind uartcsr_top uartcsr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .eng_busy(eng_busy), .rx_ready(rx_ready),
  .tx_empty(tx_empty), .line_err(line_err), .rx_timeout(rx_timeout),
  .divisor(divisor), .line_cfg(line_cfg), .irq(irq), .busy_pend(busy_pend)
);

// File: tb/uartcsr_tb.sv
module uartcsr_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic eng_busy = 0, rx_ready = 0, tx_empty = 0, line_err = 0, rx_timeout = 0;
  logic [7:0] rx_byte = '0, msr_in = '0;
  logic tx_push, rx_pop, irq;
  logic [7:0] tx_byte, line_cfg;
  logic [15:0] divisor;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_lcr = 8'h03, m_dll = 8'h01, m_dlh = 8'h00, m_scr = 8'h00;
  logic [3:0] m_ier = 4'h0;
  logic m_fifo = 0, m_pend = 0;

  always #10 clk = ~clk;

  uartcsr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .rx_ready(rx_ready), .tx_empty(tx_empty),
    .line_err(line_err), .rx_timeout(rx_timeout), .rx_byte(rx_byte),
    .msr_in(msr_in), .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .divisor(divisor), .line_cfg(line_cfg), .irq(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_code();
    if (line_err && m_ier[2]) return 4'h6;
    if (rx_ready && m_ier[0]) return 4'h4;
    if (rx_timeout && m_ier[0]) return 4'hC;
    if (tx_empty && m_ier[1]) return 4'h2;
    if (m_pend) return 4'h7;
    return 4'h1;
  endfunction

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    case (a)
      5'h00: return m_lcr[7] ? m_dll : rx_byte;
      5'h01: return m_lcr[7] ? m_dlh : {4'h0, m_ier};
      5'h02: return {m_fifo, m_fifo, 2'b00, exp_code()};
      5'h03: return m_lcr;
      5'h05: return {1'b0, tx_empty & ~eng_busy, tx_empty, 3'b000, line_err, rx_ready};
      5'h06: return msr_in;
      5'h07: return m_scr;
      5'h1F: return {7'h0, eng_busy};
      default: return 8'h00;
    endcase
  endfunction

  task automatic set_in(bit b, bit rr, bit te, bit le, bit to);
    @(negedge clk);
    eng_busy = b; rx_ready = rr; tx_empty = te; line_err = le; rx_timeout = to;
    rx_byte = 8'($urandom); msr_in = 8'($urandom);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    #2;
    chk("R8 tx_push", {15'h0, tx_push}, {15'h0, (a == 5'h00) && !m_lcr[7]});
    if (a == 5'h00 && !m_lcr[7]) chk("R8 tx_byte", {8'h0, tx_byte}, {8'h0, d});
    @(posedge clk);
    case (a)
      5'h00: if (m_lcr[7]) m_dll = d;
      5'h01: if (m_lcr[7]) m_dlh = d; else m_ier = d[3:0];
      5'h02: m_fifo = d[0];
      5'h03: if (eng_busy) m_pend = 1; else m_lcr = d;
      5'h07: m_scr = d;
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #2;
    chk(tag, {8'h0, bus_rdata}, {8'h0, exp_rd(a)});
    chk("R8 rx_pop", {15'h0, rx_pop}, {15'h0, (a == 5'h00) && !m_lcr[7]});
    @(posedge clk);
    if (a == 5'h1F) m_pend = 0;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic outs(string tag);
    #1;
    chk({tag, " line_cfg R2"}, {8'h0, line_cfg}, {8'h0, m_lcr});
    chk({tag, " divisor R7"}, divisor, {m_dlh, m_dll});
    chk({tag, " irq R6"}, {15'h0, irq}, {15'h0, exp_code() != 4'h1});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h03, "R1 lcr");
    rd(5'h01, "R1 ier");
    rd(5'h07, "R1 scr");
    rd(5'h02, "R1 iir");
    chk("R1 divisor", divisor, 16'h0001);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R2 idle write
    wr(5'h03, 8'h1B); outs("R2"); rd(5'h03, "R2 readback");

    // R3/R4 locked write with bit 7 attempted
    set_in(1, 0, 0, 0, 0);
    wr(5'h03, 8'h83); outs("R3");
    rd(5'h03, "R3 lcr kept");
    rd(5'h02, "R4 iir busy 0x7");
    chk("R4 irq", {15'h0, irq}, 16'h1);
    // R4 not maskable: ier zero, still pending
    wr(5'h01, 8'h00); rd(5'h02, "R4 unmaskable");
    // R5 status read clears and shows live busy
    rd(5'h1F, "R5 usr busy bit");
    rd(5'h02, "R5 cleared");
    set_in(0, 0, 0, 0, 0);
    rd(5'h1F, "R5 usr idle");

    // R6 priority ladder
    wr(5'h01, 8'h07);
    set_in(1, 0, 0, 0, 0); wr(5'h03, 8'h1B);
    set_in(1, 1, 1, 1, 1); rd(5'h02, "R6 line first");
    set_in(1, 1, 1, 0, 1); rd(5'h02, "R6 rx second");
    set_in(1, 0, 1, 0, 1); rd(5'h02, "R6 timeout third");
    set_in(1, 0, 1, 0, 0); rd(5'h02, "R6 tx fourth");
    set_in(1, 0, 0, 0, 0); rd(5'h02, "R6 busy last");
    rd(5'h1F, "R5 clear again");
    set_in(0, 0, 0, 0, 0); rd(5'h02, "R6 none");

    // R7 divisor sequence
    wr(5'h03, 8'h9B); wr(5'h01, 8'h12); wr(5'h00, 8'h34);
    rd(5'h00, "R7 dll"); rd(5'h01, "R7 dlh");
    wr(5'h03, 8'h1B); outs("R7");
    chk("R7 divisor value", divisor, 16'h1234);

    // R8 data path and ier
    wr(5'h00, 8'hA5); rd(5'h00, "R8 rx_byte"); wr(5'h01, 8'hFD); rd(5'h01, "R8 ier");
    // R9, R10, R11
    wr(5'h07, 8'h5A); rd(5'h07, "R9 scratch"); rd(5'h06, "R9 msr");
    wr(5'h02, 8'h01); rd(5'h02, "R10 fifo on");
    wr(5'h02, 8'h00); rd(5'h02, "R10 fifo off");
    set_in(1, 1, 1, 1, 0); rd(5'h05, "R11 lsr"); rd(5'h04, "R11 unmapped");
    set_in(0, 0, 1, 0, 0); rd(5'h05, "R11 lsr idle");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      logic [7:0] d;
      int k;
      set_in(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      d = 8'($urandom);
      k = $urandom_range(0, 8);
      case (k)
        0: a = 5'h00; 1: a = 5'h01; 2: a = 5'h02; 3: a = 5'h03;
        4: a = 5'h04; 5: a = 5'h05; 6: a = 5'h06; 7: a = 5'h07;
        default: a = 5'h1F;
      endcase
      if ($urandom_range(0, 1) == 0 && a inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h07})
        wr(a, d);
      else
        rd(a, "R6 R9 R11 random read");
      outs("random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule